// File: doc/BRIEF.md
# Queue Status Edge-Interrupt Controller

This block watches a set of queues, each of which reports three status flags: a ready flag and two general flags, A and B. Every edge of interest on those flags is caught and held as a sticky bit in a status register. The host reads that status register through a small register port, and the read clears it. The ready flag is watched for both rising and falling edges. The A and B flags are watched for rising edges only.

A mask register lines up bit for bit with the status register. It decides which sticky bits may drive one summary interrupt line toward the host's interrupt logic. The mask only affects that summary line. Every event is still latched and cleared, whatever its mask bit says.

The flags are assumed to be synchronous to the block clock. The host sees read data one cycle after it asserts the read strobe.

Top module: `qsiIrqCtl`

## Requirements
- R1: Queue n owns status bits 4n+3 down to 4n. Inside each field, bit 3 flags a ready rising edge, bit 2 a ready falling edge, bit 1 an A rising edge and bit 0 a B rising edge.
- R2: A ready flag that changes level sets the matching rising-edge or falling-edge bit at the clock edge where the new level is first sampled.
- R3: A falling edge on an A or B flag sets no status bit.
- R4: A status bit that is set stays set until the status register is read.
- R5: A read at offset 0 returns the status value on `regRdData` one cycle after the strobe, and the same clock edge clears every status bit.
- R6: If an event happens in the same cycle as a status read, the read returns the old value and the new event stays latched.
- R7: The mask register at offset 4 is written from `regWrData` and reads back its value one cycle after the read strobe.
- R8: A write at offset 0 changes neither the status register nor the mask register.
- R9: After each clock edge, `irqOut` equals the OR over all bits of (status AND mask) as they stood before that edge.
- R10: A status bit whose mask bit is clear still sets on its event and clears on a read, but it does not raise `irqOut`.
- R11: After reset, the status register, the mask register, `irqOut` and `regRdData` are all zero.
- R12: A read at any offset other than 0 or 4 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W (4) | Register byte offset |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regWrData | input | NUM_QUEUES*4 (32) | Write data |
| regRdData | output | NUM_QUEUES*4 (32) | Registered read data |
| queueReady | input | NUM_QUEUES (8) | Ready flag, one per queue |
| queueFlagA | input | NUM_QUEUES (8) | Status flag A, one per queue |
| queueFlagB | input | NUM_QUEUES (8) | Status flag B, one per queue |
| irqOut | output | 1 | Registered summary interrupt |

## Verification
The bench builds the block with its default parameters: eight queues, which makes a 32-bit register, and a 4-bit address. With these values it can drive events into the lowest field (queue 0), the highest field (queue 7) and fields in between. That checks the field placement at both ends of the register. The 4-bit address also reaches an offset that decodes to no register, so the zero read-back of unused offsets can be tested.

// File: rtl/qsiPkg.sv
package qsiPkg;
  localparam int FIELD_W      = 4;
  localparam int BIT_RDY_RISE = 3;
  localparam int BIT_RDY_FALL = 2;
  localparam int BIT_A_RISE   = 1;
  localparam int BIT_B_RISE   = 0;

  typedef struct packed {
    logic rdStatus;
    logic rdMask;
    logic rdOther;
    logic wrMask;
  } qsiStrobes_t;
endpackage

// File: rtl/qsiCtl.sv
module qsiCtl
  import qsiPkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STATUS_OFS = 0,
  parameter int MASK_OFS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  output qsiStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] MASK_ADDR   = ADDR_W'(MASK_OFS);

  logic hitStatus;
  logic hitMask;

  assign hitStatus = (regAddr == STATUS_ADDR);
  assign hitMask   = (regAddr == MASK_ADDR);

  always_comb begin
    strobes          = '0;
    strobes.rdStatus = regRd & hitStatus;
    strobes.rdMask   = regRd & hitMask;
    strobes.rdOther  = regRd & ~hitStatus & ~hitMask;
    // writes at the status offset (or any other offset) produce no strobe
    strobes.wrMask   = regWr & hitMask;
  end

  // a read selects at most one source
  assert_read_decode_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdStatus, strobes.rdMask, strobes.rdOther}));

  // a read strobe always selects some source
  assert_read_covered_R12: assert property (@(posedge clk) disable iff (!rstN)
    regRd |-> (|{strobes.rdStatus, strobes.rdMask, strobes.rdOther}));
endmodule

// File: rtl/qsiDatapath.sv
module qsiDatapath
  import qsiPkg::*;
#(
  parameter int NUM_QUEUES = 8,
  localparam int DATA_W = NUM_QUEUES * FIELD_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  qsiStrobes_t           strobes,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_QUEUES-1:0] queueReady,
  input  logic [NUM_QUEUES-1:0] queueFlagA,
  input  logic [NUM_QUEUES-1:0] queueFlagB,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irqOut
);
  logic [NUM_QUEUES-1:0] rdyPrev;
  logic [NUM_QUEUES-1:0] aPrev;
  logic [NUM_QUEUES-1:0] bPrev;
  logic [DATA_W-1:0]     eventVec;
  logic [DATA_W-1:0]     status;
  logic [DATA_W-1:0]     statusNext;
  logic [DATA_W-1:0]     mask;

  // per-queue edge detectors feeding one status field
  for (genvar q = 0; q < NUM_QUEUES; q++) begin : gQueue
    assign eventVec[q*FIELD_W + BIT_RDY_RISE] =  queueReady[q] & ~rdyPrev[q];
    assign eventVec[q*FIELD_W + BIT_RDY_FALL] = ~queueReady[q] &  rdyPrev[q];
    assign eventVec[q*FIELD_W + BIT_A_RISE]   =  queueFlagA[q] & ~aPrev[q];
    assign eventVec[q*FIELD_W + BIT_B_RISE]   =  queueFlagB[q] & ~bPrev[q];
  end

  // a new event wins over the clear that a read causes
  always_comb begin
    statusNext = strobes.rdStatus ? '0 : status;
    statusNext = statusNext | eventVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyPrev <= '0;
      aPrev   <= '0;
      bPrev   <= '0;
    end else begin
      rdyPrev <= queueReady;
      aPrev   <= queueFlagA;
      bPrev   <= queueFlagB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= statusNext;
      if (strobes.wrMask) mask <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      rdData <= '0;
    end else begin
      irqOut <= |(status & mask);
      if (strobes.rdStatus)     rdData <= status;
      else if (strobes.rdMask)  rdData <= mask;
      else if (strobes.rdOther) rdData <= '0;
    end
  end

  // without a read, bits already set remain set
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdStatus |=> ((status & $past(status)) == $past(status)));

  // after a read only the events of that cycle survive
  assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdStatus |=> ((status & ~$past(eventVec)) == '0));

  // a bit can only become set through a detected event
  assert_set_by_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((status & ~$past(status) & ~$past(eventVec)) == '0));

  // the summary line follows the masked status one cycle later
  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (irqOut == $past(|(status & mask))));

  // the mask changes only through its own write
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrMask |=> $stable(mask));
endmodule

// File: rtl/qsiIrqCtl.sv
module qsiIrqCtl
  import qsiPkg::*;
#(
  parameter int NUM_QUEUES = 8,
  parameter int ADDR_W     = 4,
  localparam int DATA_W = NUM_QUEUES * FIELD_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regRd,
  input  logic                  regWr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [NUM_QUEUES-1:0] queueReady,
  input  logic [NUM_QUEUES-1:0] queueFlagA,
  input  logic [NUM_QUEUES-1:0] queueFlagB,
  output logic                  irqOut
);
  qsiStrobes_t strobes;

  qsiCtl #(.ADDR_W(ADDR_W), .STATUS_OFS(0), .MASK_OFS(4)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regRd   (regRd),
    .regWr   (regWr),
    .strobes (strobes)
  );

  qsiDatapath #(.NUM_QUEUES(NUM_QUEUES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (regWrData),
    .queueReady (queueReady),
    .queueFlagA (queueFlagA),
    .queueFlagB (queueFlagB),
    .rdData     (regRdData),
    .irqOut     (irqOut)
  );
endmodule

// File: tb/qsiIrqCtl_tb.sv
module qsiIrqCtl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  queueReady = '0;
  logic [7:0]  queueFlagA = '0;
  logic [7:0]  queueFlagB = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state, built from the requirements
  logic [31:0] mStatus = '0;
  logic [31:0] mMask = '0;
  logic [7:0]  mRdy = '0, mA = '0, mB = '0;

  // scoreboard queues
  bit          chkQ[$];
  logic [31:0] expRdQ[$];
  bit          irqQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  qsiIrqCtl u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .queueReady(queueReady),
    .queueFlagA(queueFlagA), .queueFlagB(queueFlagB), .irqOut(irqOut)
  );

  // driver: applies one cycle of stimulus at a falling edge and pushes the expectation
  task automatic step(input logic [7:0] rdy, input logic [7:0] a, input logic [7:0] b,
                      input bit rd, input bit wr, input logic [3:0] addr,
                      input logic [31:0] wd, input string tag);
    logic [31:0] ev;
    logic [31:0] exp;
    ev = '0;
    for (int q = 0; q < 8; q++) begin
      ev[4*q+3] =  rdy[q] & ~mRdy[q];
      ev[4*q+2] = ~rdy[q] &  mRdy[q];
      ev[4*q+1] =  a[q]   & ~mA[q];
      ev[4*q]   =  b[q]   & ~mB[q];
    end
    exp = (addr == 4'd0) ? mStatus : (addr == 4'd4) ? mMask : 32'h0;
    chkQ.push_back(rd);
    expRdQ.push_back(exp);
    irqQ.push_back(|(mStatus & mMask));
    tagQ.push_back(tag);
    if (rd && addr == 4'd0) mStatus = '0;
    mStatus = mStatus | ev;
    if (wr && addr == 4'd4) mMask = wd;
    mRdy = rdy; mA = a; mB = b;
    queueReady = rdy; queueFlagA = a; queueFlagB = b;
    regRd = rd; regWr = wr; regAddr = addr; regWrData = wd;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(mRdy, mA, mB, 0, 0, 4'd0, 32'h0, tag);
  endtask

  task automatic rdReg(input logic [3:0] addr, input string tag);
    step(mRdy, mA, mB, 1, 0, addr, 32'h0, tag);
  endtask

  task automatic wrReg(input logic [3:0] addr, input logic [31:0] d, input string tag);
    step(mRdy, mA, mB, 0, 1, addr, d, tag);
  endtask

  task automatic setIn(input logic [7:0] rdy, input logic [7:0] a, input logic [7:0] b,
                       input string tag);
    step(rdy, a, b, 0, 0, 4'd0, 32'h0, tag);
  endtask

  // monitor: pops one expectation per rising edge and compares after it settles
  always @(posedge clk) begin
    bit          c;
    logic [31:0] er;
    bit          ei;
    string       t;
    if (chkQ.size() > 0) begin
      c  = chkQ.pop_front();
      er = expRdQ.pop_front();
      ei = irqQ.pop_front();
      t  = tagQ.pop_front();
      #2;
      checks++;
      if (irqOut !== ei) begin
        errors++;
        $display("FAIL R9 (%s): irqOut actual %0b expected %0b", t, irqOut, ei);
      end
      if (c) begin
        checks++;
        if (regRdData !== er) begin
          errors++;
          $display("FAIL %s: regRdData actual %08h expected %08h", t, regRdData, er);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: state straight after reset
    checks++;
    if (regRdData !== 32'h0 || irqOut !== 1'b0) begin
      errors++;
      $display("FAIL R11: rdData/irq actual %08h/%0b expected 0/0", regRdData, irqOut);
    end
    rstN = 1'b1;
    @(negedge clk);
    rdReg(4'd0, "R11 status reset");
    rdReg(4'd4, "R11 mask reset");

    // R1 R2: ready rise on queue 3 lands in bit 15
    setIn(8'h08, 8'h00, 8'h00, "R2 rise");
    idle("R4 hold");
    rdReg(4'd0, "R1 ready rise q3");
    // R2: ready fall on queue 3 lands in bit 14
    setIn(8'h00, 8'h00, 8'h00, "R2 fall");
    rdReg(4'd0, "R2 ready fall q3");
    // R1: A rise on queue 5 (bit 21) and B rise on queue 0 (bit 0)
    setIn(8'h00, 8'h20, 8'h01, "R1 A/B rise");
    rdReg(4'd0, "R1 A q5 B q0");
    // R3: A/B falls set nothing
    setIn(8'h00, 8'h00, 8'h00, "R3 A/B fall");
    idle("R3 idle");
    rdReg(4'd0, "R3 falls quiet");
    // R4 R5: queue 7 ready rise held over idle cycles, then cleared by the read
    setIn(8'h80, 8'h00, 8'h00, "R4 q7 rise");
    repeat (3) idle("R4 hold");
    rdReg(4'd0, "R4 sticky q7");
    rdReg(4'd0, "R5 cleared after read");
    // R6: event in the same cycle as the read
    step(8'h82, 8'h00, 8'h00, 1, 0, 4'd0, 32'h0, "R6 read with event");
    rdReg(4'd0, "R6 event kept");
    // R8: write at offset 0 leaves status and mask alone
    setIn(8'h82, 8'h01, 8'h00, "R8 setup");
    wrReg(4'd0, 32'hFFFF_FFFF, "R8 write status");
    rdReg(4'd0, "R8 status unchanged");
    rdReg(4'd4, "R8 mask unchanged");
    // R7: mask write and read back
    wrReg(4'd4, 32'h0000_00F0, "R7 write mask");
    rdReg(4'd4, "R7 mask readback");
    // R10: masked event on queue 2 latches without irq
    setIn(8'h82, 8'h05, 8'h00, "R10 masked event");
    repeat (2) idle("R10 no irq");
    rdReg(4'd0, "R10 masked bit latched");
    idle("R10 cleared");
    // R9: unmasked event on queue 1 raises irq, read clears it
    setIn(8'h82, 8'h05, 8'h02, "R9 unmasked event");
    repeat (2) idle("R9 irq high");
    rdReg(4'd0, "R9 read q1 B");
    repeat (2) idle("R9 irq low");
    // R12: unused offset reads zero
    wrReg(4'd4, 32'hA5A5_0000, "R12 mask setup");
    rdReg(4'd8, "R12 unused offset");
    rdReg(4'd4, "R7 mask readback 2");
    repeat (2) idle("drain");
    @(posedge clk);
    #5;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule